// File: doc/BRIEF.md
# In-Order Shift-Register Issue Window

This block holds up to four decoded instructions in program order and each cycle picks the longest run from the head of the window that may start together. The pick draws on six execution resources: two integer units, two FP/graphics units, one memory unit and one branch unit. Each issuing slot receives one unit number. Every instruction carries a class, a store flag, a write flag, a destination register and two source registers. Inside a group, a consumer that reads a result produced earlier in the same group does not issue. The one exception is a store whose data operand comes from an integer result in that group; that pair issues together. A branch closes its group.

After a group issues, the entries that are left move up to the head by the number that issued. The fetch side offers up to four instructions per cycle on lanes with a valid and a ready bit each. Ready is raised only on as many lanes as there are free entries, counted from lane 0. Accepted lanes fill the tail behind the remaining entries. A flush empties the window in one cycle.

Top module: `iw_issue_window`

## Requirements
- R1: After reset the window is empty: `issue_valid` is 0 and `fetch_ready` has every bit set.
- R2: `fetch_ready` is set on lanes 0 to F-1 and clear on the others, where F is the number of entries free after the current cycle's issue. The leading run of lanes with both valid and ready set is written, in lane order, behind the entries that remain. A lane that is valid without ready is not taken.
- R3: Slot i of the issue outputs corresponds to window entry i (the head is slot 0). `issue_valid` is always a run of ones starting at bit 0. Up to four slots may issue in one cycle. The first entry that cannot issue stops every entry behind it.
- R4: The class field is 2 bits per lane: 0 integer, 1 FP/graphics, 2 memory, 3 branch. At most two integer, two FP, one memory and one branch instruction issue per cycle. Unit numbers are 0 and 1 for integer, 2 and 3 for FP, 4 for memory and 5 for branch. The k-th instruction of a class in a group gets that class's k-th unit.
- R5: The last slot (entry 3) issues only an FP or branch instruction.
- R6: An entry stops issue when either of its sources equals the destination of an earlier entry in the same group that has its write flag set. The exception is a memory entry with its store flag set whose second source (store data) matches an integer producer; that entry still issues.
- R7: No entry after a branch issues in the branch's cycle.
- R8: After a group of n issues, the entries that did not issue move to positions 0, 1, ... in their original order on the next cycle.
- R9: While `flush` is high, `issue_valid` and `fetch_ready` are 0. On the next cycle the window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every window entry |
| fetch_valid | input | DEPTH | Per-lane offer from fetch |
| fetch_ready | output | DEPTH | Per-lane acceptance, lanes 0 up to the free count |
| fetch_cls | input | 2*DEPTH | Class code per lane |
| fetch_store | input | DEPTH | Store flag per lane (memory class) |
| fetch_wr | input | DEPTH | Destination-write flag per lane |
| fetch_dst | input | REG_W*DEPTH | Destination register per lane |
| fetch_src1 | input | REG_W*DEPTH | First source (address for memory ops) per lane |
| fetch_src2 | input | REG_W*DEPTH | Second source (store data for stores) per lane |
| issue_valid | output | DEPTH | Per-slot issue strobe |
| issue_unit | output | UNIT_W*DEPTH | Assigned unit number per slot |
| issue_dst | output | REG_W*DEPTH | Destination field of the entry in each slot |

## Verification
The bench builds the window with its default parameters: four entries, 5-bit register numbers, two integer, two FP, one memory and one branch unit, and the last-slot rule enabled. With four entries, a single load can bring a third integer instruction into the group, which exhausts the integer units. It can also put a memory operation in the restricted last slot, or place a producer next to a consumer. With one memory unit, a store and its producer must share a group for the data-forwarding exception to apply. A full four-wide group and a partial issue followed by a refill on the same cycle are both reachable from one fetch beat.

// File: rtl/iw_pkg.sv
package iw_pkg;

   // Instruction class; the numeric order also indexes the unit tables.
   typedef enum logic [1:0] {
      CL_INT = 2'd0,
      CL_FP  = 2'd1,
      CL_MEM = 2'd2,
      CL_BR  = 2'd3
   } iw_cls_e;

   localparam int unsigned IW_NUM_CLS = 4;

endpackage

// File: rtl/iw_window.sv
// Shift-register storage: compacts by the issued count and appends fetch lanes.
module iw_window
   import iw_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned REG_W = 5,
   parameter int unsigned CNT_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [CNT_W-1:0] n_issue_i,
   input  logic [DEPTH-1:0] f_vld_i,
   input  iw_cls_e          f_cls_i [DEPTH],
   input  logic [DEPTH-1:0] f_st_i,
   input  logic [DEPTH-1:0] f_wr_i,
   input  logic [REG_W-1:0] f_dst_i [DEPTH],
   input  logic [REG_W-1:0] f_s1_i  [DEPTH],
   input  logic [REG_W-1:0] f_s2_i  [DEPTH],
   output logic [DEPTH-1:0] f_rdy_o,
   output logic [DEPTH-1:0] vld_o,
   output iw_cls_e          cls_o [DEPTH],
   output logic [DEPTH-1:0] st_o,
   output logic [DEPTH-1:0] wr_o,
   output logic [REG_W-1:0] dst_o [DEPTH],
   output logic [REG_W-1:0] s1_o  [DEPTH],
   output logic [REG_W-1:0] s2_o  [DEPTH]
);

   typedef struct packed {
      iw_cls_e          cls;
      logic             st;
      logic             wr;
      logic [REG_W-1:0] dst;
      logic [REG_W-1:0] s1;
      logic [REG_W-1:0] s2;
   } ent_t;

   ent_t             q_e [DEPTH];
   ent_t             f_e [DEPTH];
   ent_t             d_e [DEPTH];
   logic [DEPTH-1:0] q_v;
   logic [DEPTH-1:0] d_v;

   for (genvar i = 0; i < DEPTH; i++) begin : g_lane
      assign f_e[i]   = {f_cls_i[i], f_st_i[i], f_wr_i[i], f_dst_i[i], f_s1_i[i], f_s2_i[i]};
      assign cls_o[i] = q_e[i].cls;
      assign st_o[i]  = q_e[i].st;
      assign wr_o[i]  = q_e[i].wr;
      assign dst_o[i] = q_e[i].dst;
      assign s1_o[i]  = q_e[i].s1;
      assign s2_o[i]  = q_e[i].s2;
   end
   assign vld_o = q_v;

   always_comb begin
      int   n_vld;
      int   rem;
      int   room;
      int   n_acc;
      int   shift;
      logic take;
      n_vld = 0;
      for (int i = 0; i < DEPTH; i++) begin
         n_vld = n_vld + int'(q_v[i]);
      end
      shift = int'(n_issue_i);
      rem   = n_vld - shift;
      room  = int'(DEPTH) - rem;
      for (int i = 0; i < DEPTH; i++) begin
         f_rdy_o[i] = !flush && (i < room);
      end
      n_acc = 0;
      take  = 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
         if (take && f_vld_i[i] && f_rdy_o[i]) begin
            n_acc = n_acc + 1;
         end else begin
            take = 1'b0;
         end
      end
      for (int i = 0; i < DEPTH; i++) begin
         d_v[i] = 1'b0;
         d_e[i] = q_e[i];
         if (i < rem) begin
            if (i + shift < int'(DEPTH)) begin
               d_v[i] = 1'b1;
               d_e[i] = q_e[i + shift];
            end
         end else if (i - rem < n_acc) begin
            d_v[i] = 1'b1;
            d_e[i] = f_e[i - rem];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         q_v <= '0;
      end else begin
         q_v <= d_v;
      end
   end

   always_ff @(posedge clk) begin
      q_e <= d_e;
   end

endmodule

// File: rtl/iw_hazard.sv
// Per-slot in-group hazard: read-after-write on an older entry, or an older branch.
module iw_hazard
   import iw_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned REG_W = 5,
   parameter int unsigned IDX   = 0
)(
   input  iw_cls_e          cls_i [DEPTH],
   input  logic [DEPTH-1:0] wr_i,
   input  logic [REG_W-1:0] dst_i [DEPTH],
   input  iw_cls_e          me_cls,
   input  logic             me_st,
   input  logic [REG_W-1:0] me_s1,
   input  logic [REG_W-1:0] me_s2,
   output logic             blk_o
);

   logic store_me;
   assign store_me = (me_cls == CL_MEM) && me_st;

   always_comb begin
      logic raw;
      logic br_older;
      raw      = 1'b0;
      br_older = 1'b0;
      for (int k = 0; k < int'(IDX); k++) begin
         if (cls_i[k] == CL_BR) begin
            br_older = 1'b1;
         end
         if (wr_i[k] && (dst_i[k] == me_s1)) begin
            raw = 1'b1;
         end
         if (wr_i[k] && (dst_i[k] == me_s2) && !(store_me && (cls_i[k] == CL_INT))) begin
            raw = 1'b1;
         end
      end
      blk_o = raw || br_older;
   end

endmodule

// File: rtl/iw_select.sv
// In-order prefix selection against per-class unit budgets and the tail-slot rule.
module iw_select
   import iw_pkg::*;
#(
   parameter int unsigned DEPTH      = 4,
   parameter int unsigned N_INT      = 2,
   parameter int unsigned N_FP       = 2,
   parameter int unsigned N_MEM      = 1,
   parameter int unsigned N_BR       = 1,
   parameter bit          LAST_FP_BR = 1'b1,
   parameter int unsigned UNIT_W     = 3,
   parameter int unsigned CNT_W      = 3
)(
   input  logic [DEPTH-1:0]  vld_i,
   input  logic [DEPTH-1:0]  blk_i,
   input  iw_cls_e           cls_i [DEPTH],
   output logic [DEPTH-1:0]  go_o,
   output logic [UNIT_W-1:0] unit_o [DEPTH],
   output logic [CNT_W-1:0]  n_issue_o
);

   localparam int LIM  [IW_NUM_CLS] = '{int'(N_INT), int'(N_FP), int'(N_MEM), int'(N_BR)};
   localparam int BASE [IW_NUM_CLS] = '{0, int'(N_INT), int'(N_INT + N_FP), int'(N_INT + N_FP + N_MEM)};

   logic [DEPTH-1:0] slot_ok;

   if (LAST_FP_BR) begin : g_tail_rule
      for (genvar j = 0; j < DEPTH; j++) begin : g_slot
         if (j == DEPTH - 1) begin : g_last
            assign slot_ok[j] = (cls_i[j] == CL_FP) || (cls_i[j] == CL_BR);
         end else begin : g_any
            assign slot_ok[j] = 1'b1;
         end
      end
   end else begin : g_no_rule
      assign slot_ok = '1;
   end

   always_comb begin
      int   used [IW_NUM_CLS];
      int   n;
      int   c;
      logic open;
      for (int k = 0; k < int'(IW_NUM_CLS); k++) begin
         used[k] = 0;
      end
      n    = 0;
      open = 1'b1;
      for (int j = 0; j < DEPTH; j++) begin
         c         = int'(cls_i[j]);
         go_o[j]   = 1'b0;
         unit_o[j] = '0;
         if (open && vld_i[j] && !blk_i[j] && slot_ok[j] && (used[c] < LIM[c])) begin
            go_o[j]   = 1'b1;
            unit_o[j] = UNIT_W'(BASE[c] + used[c]);
            used[c]   = used[c] + 1;
            n         = n + 1;
         end else begin
            open = 1'b0;
         end
      end
      n_issue_o = CNT_W'(n);
   end

endmodule

// File: rtl/iw_issue_window.sv
module iw_issue_window
   import iw_pkg::*;
#(
   parameter int unsigned DEPTH      = 4,
   parameter int unsigned REG_W      = 5,
   parameter int unsigned N_INT      = 2,
   parameter int unsigned N_FP       = 2,
   parameter int unsigned N_MEM      = 1,
   parameter int unsigned N_BR       = 1,
   parameter bit          LAST_FP_BR = 1'b1,
   localparam int unsigned UNIT_W    = $clog2(N_INT + N_FP + N_MEM + N_BR),
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    flush,
   input  logic [DEPTH-1:0]        fetch_valid,
   output logic [DEPTH-1:0]        fetch_ready,
   input  logic [2*DEPTH-1:0]      fetch_cls,
   input  logic [DEPTH-1:0]        fetch_store,
   input  logic [DEPTH-1:0]        fetch_wr,
   input  logic [REG_W*DEPTH-1:0]  fetch_dst,
   input  logic [REG_W*DEPTH-1:0]  fetch_src1,
   input  logic [REG_W*DEPTH-1:0]  fetch_src2,
   output logic [DEPTH-1:0]        issue_valid,
   output logic [UNIT_W*DEPTH-1:0] issue_unit,
   output logic [REG_W*DEPTH-1:0]  issue_dst
);

   if (DEPTH < 2) begin : g_chk_depth
      $error("iw_issue_window: DEPTH must be at least 2");
   end
   if (REG_W < 1) begin : g_chk_regw
      $error("iw_issue_window: REG_W must be at least 1");
   end
   if ((N_INT < 1) || (N_FP < 1) || (N_MEM < 1) || (N_BR < 1)) begin : g_chk_units
      $error("iw_issue_window: every class needs at least one unit");
   end

   iw_cls_e           f_cls [DEPTH];
   logic [REG_W-1:0]  f_dst [DEPTH];
   logic [REG_W-1:0]  f_s1  [DEPTH];
   logic [REG_W-1:0]  f_s2  [DEPTH];

   logic [DEPTH-1:0]  w_vld;
   iw_cls_e           w_cls [DEPTH];
   logic [DEPTH-1:0]  w_st;
   logic [DEPTH-1:0]  w_wr;
   logic [REG_W-1:0]  w_dst [DEPTH];
   logic [REG_W-1:0]  w_s1  [DEPTH];
   logic [REG_W-1:0]  w_s2  [DEPTH];

   logic [DEPTH-1:0]  blk;
   logic [DEPTH-1:0]  go;
   logic [UNIT_W-1:0] sel_unit [DEPTH];
   logic [CNT_W-1:0]  n_iss;
   logic [CNT_W-1:0]  n_iss_g;

   for (genvar i = 0; i < DEPTH; i++) begin : g_io
      assign f_cls[i] = iw_cls_e'(fetch_cls[2*i +: 2]);
      assign f_dst[i] = fetch_dst [REG_W*i +: REG_W];
      assign f_s1[i]  = fetch_src1[REG_W*i +: REG_W];
      assign f_s2[i]  = fetch_src2[REG_W*i +: REG_W];
      assign issue_unit[UNIT_W*i +: UNIT_W] = sel_unit[i];
      assign issue_dst [REG_W*i  +: REG_W]  = w_dst[i];
   end

   iw_window #(
      .DEPTH (DEPTH),
      .REG_W (REG_W),
      .CNT_W (CNT_W)
   ) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .n_issue_i (n_iss_g),
      .f_vld_i   (fetch_valid),
      .f_cls_i   (f_cls),
      .f_st_i    (fetch_store),
      .f_wr_i    (fetch_wr),
      .f_dst_i   (f_dst),
      .f_s1_i    (f_s1),
      .f_s2_i    (f_s2),
      .f_rdy_o   (fetch_ready),
      .vld_o     (w_vld),
      .cls_o     (w_cls),
      .st_o      (w_st),
      .wr_o      (w_wr),
      .dst_o     (w_dst),
      .s1_o      (w_s1),
      .s2_o      (w_s2)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_haz
      iw_hazard #(
         .DEPTH (DEPTH),
         .REG_W (REG_W),
         .IDX   (i)
      ) u_haz (
         .cls_i  (w_cls),
         .wr_i   (w_wr),
         .dst_i  (w_dst),
         .me_cls (w_cls[i]),
         .me_st  (w_st[i]),
         .me_s1  (w_s1[i]),
         .me_s2  (w_s2[i]),
         .blk_o  (blk[i])
      );
   end

   iw_select #(
      .DEPTH      (DEPTH),
      .N_INT      (N_INT),
      .N_FP       (N_FP),
      .N_MEM      (N_MEM),
      .N_BR       (N_BR),
      .LAST_FP_BR (LAST_FP_BR),
      .UNIT_W     (UNIT_W),
      .CNT_W      (CNT_W)
   ) u_sel (
      .vld_i     (w_vld),
      .blk_i     (blk),
      .cls_i     (w_cls),
      .go_o      (go),
      .unit_o    (sel_unit),
      .n_issue_o (n_iss)
   );

   assign n_iss_g     = flush ? '0 : n_iss;
   assign issue_valid = flush ? '0 : go;

endmodule

// File: rtl/iw_issue_window_chk.sv
module iw_issue_window_chk #(
   parameter int unsigned DEPTH      = 4,
   parameter int unsigned N_INT      = 2,
   parameter int unsigned N_FP       = 2,
   parameter int unsigned N_MEM      = 1,
   parameter int unsigned N_BR       = 1,
   parameter bit          LAST_FP_BR = 1'b1,
   parameter int unsigned UNIT_W     = 3
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    flush,
   input logic [DEPTH-1:0]        fetch_ready,
   input logic [DEPTH-1:0]        issue_valid,
   input logic [UNIT_W*DEPTH-1:0] issue_unit
);

   localparam int unsigned FP_LO = N_INT;
   localparam int unsigned FP_HI = N_INT + N_FP - 1;
   localparam int unsigned BR_LO = N_INT + N_FP + N_MEM;
   localparam int unsigned BR_HI = BR_LO + N_BR - 1;

   logic [DEPTH-1:0] iss_inc;
   logic [DEPTH-1:0] rdy_inc;
   logic             dup;

   assign iss_inc = issue_valid + 1'b1;
   assign rdy_inc = fetch_ready + 1'b1;

   always_comb begin
      dup = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         for (int j = i + 1; j < DEPTH; j++) begin
            if (issue_valid[i] && issue_valid[j] &&
                (issue_unit[UNIT_W*i +: UNIT_W] == issue_unit[UNIT_W*j +: UNIT_W])) begin
               dup = 1'b1;
            end
         end
      end
   end

   AST_ISSUE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n) (iss_inc & issue_valid) == '0); // R3
   AST_READY_PREFIX: assert property (@(posedge clk) disable iff (!rst_n) (rdy_inc & fetch_ready) == '0); // R2
   AST_UNIT_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n) !dup); // R4
   AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n) flush |-> (issue_valid == '0) && (fetch_ready == '0)); // R9
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (flush || (&fetch_ready))); // R9

   for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_brk
      AST_BRANCH_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_valid[i] && (int'(issue_unit[UNIT_W*i +: UNIT_W]) >= int'(BR_LO))
                         && (int'(issue_unit[UNIT_W*i +: UNIT_W]) <= int'(BR_HI)))
         |-> !issue_valid[i+1]); // R7
   end

   if (LAST_FP_BR) begin : g_tail
      AST_TAIL_KIND: assert property (@(posedge clk) disable iff (!rst_n)
         issue_valid[DEPTH-1] |->
            (((int'(issue_unit[UNIT_W*(DEPTH-1) +: UNIT_W]) >= int'(FP_LO)) &&
              (int'(issue_unit[UNIT_W*(DEPTH-1) +: UNIT_W]) <= int'(FP_HI))) ||
             ((int'(issue_unit[UNIT_W*(DEPTH-1) +: UNIT_W]) >= int'(BR_LO)) &&
              (int'(issue_unit[UNIT_W*(DEPTH-1) +: UNIT_W]) <= int'(BR_HI))))); // R5
   end

endmodule

bind iw_issue_window iw_issue_window_chk #(
   .DEPTH      (DEPTH),
   .N_INT      (N_INT),
   .N_FP       (N_FP),
   .N_MEM      (N_MEM),
   .N_BR       (N_BR),
   .LAST_FP_BR (LAST_FP_BR),
   .UNIT_W     (UNIT_W)
) u_chk (.*);

// File: tb/sim_iw_issue_window.sv
module sim_iw_issue_window;

   localparam int CLK_P = 10;
   localparam logic [1:0] C_I = 2'd0, C_F = 2'd1, C_M = 2'd2, C_B = 2'd3;

   typedef struct packed {
      logic [1:0] cls;
      logic       st;
      logic       wr;
      logic [4:0] dst;
      logic [4:0] s1;
      logic [4:0] s2;
   } ins_t;

   typedef struct {
      logic [3:0]  mask;
      logic [11:0] unit;
      logic [19:0] dst;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [3:0]  fetch_valid = '0;
   logic [7:0]  fetch_cls = '0;
   logic [3:0]  fetch_store = '0;
   logic [3:0]  fetch_wr = '0;
   logic [19:0] fetch_dst = '0;
   logic [19:0] fetch_src1 = '0;
   logic [19:0] fetch_src2 = '0;
   logic [3:0]  fetch_ready;
   logic [3:0]  issue_valid;
   logic [11:0] issue_unit;
   logic [19:0] issue_dst;

   int   total = 0;
   int   bad = 0;
   exp_t exq [$];

   always #(CLK_P/2) clk = ~clk;

   iw_issue_window u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .fetch_valid (fetch_valid),
      .fetch_ready (fetch_ready),
      .fetch_cls   (fetch_cls),
      .fetch_store (fetch_store),
      .fetch_wr    (fetch_wr),
      .fetch_dst   (fetch_dst),
      .fetch_src1  (fetch_src1),
      .fetch_src2  (fetch_src2),
      .issue_valid (issue_valid),
      .issue_unit  (issue_unit),
      .issue_dst   (issue_dst)
   );

   task automatic check(input bit ok, input string msg);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s", msg);
      end
   endtask

   function automatic ins_t op_int(int d, int a, int b);
      return {C_I, 1'b0, 1'b1, 5'(d), 5'(a), 5'(b)};
   endfunction
   function automatic ins_t op_fp(int d, int a, int b);
      return {C_F, 1'b0, 1'b1, 5'(d), 5'(a), 5'(b)};
   endfunction
   function automatic ins_t op_ld(int d, int a);
      return {C_M, 1'b0, 1'b1, 5'(d), 5'(a), 5'd29};
   endfunction
   function automatic ins_t op_st(int a, int b);
      return {C_M, 1'b1, 1'b0, 5'd13, 5'(a), 5'(b)};
   endfunction
   function automatic ins_t op_br();
      return {C_B, 1'b0, 1'b0, 5'd9, 5'd30, 5'd31};
   endfunction

   function automatic logic [11:0] u4(int a, int b, int c, int d);
      return {3'(d), 3'(c), 3'(b), 3'(a)};
   endfunction
   function automatic logic [19:0] d4(int a, int b, int c, int d);
      return {5'(d), 5'(c), 5'(b), 5'(a)};
   endfunction

   task automatic push(input logic [3:0] m, input logic [11:0] u, input logic [19:0] d, input string t);
      exp_t e;
      e.mask = m;
      e.unit = u;
      e.dst  = d;
      e.tag  = t;
      exq.push_back(e);
   endtask

   task automatic set_lanes(input ins_t l0, input ins_t l1, input ins_t l2, input ins_t l3, input logic [3:0] v);
      ins_t ln [4];
      ln[0] = l0; ln[1] = l1; ln[2] = l2; ln[3] = l3;
      for (int i = 0; i < 4; i++) begin
         fetch_cls[2*i +: 2]  = ln[i].cls;
         fetch_store[i]       = ln[i].st;
         fetch_wr[i]          = ln[i].wr;
         fetch_dst[5*i +: 5]  = ln[i].dst;
         fetch_src1[5*i +: 5] = ln[i].s1;
         fetch_src2[5*i +: 5] = ln[i].s2;
      end
      fetch_valid = v;
   endtask

   task automatic load(input ins_t l0, input ins_t l1, input ins_t l2, input ins_t l3);
      @(negedge clk);
      #1;
      set_lanes(l0, l1, l2, l3, 4'b1111);
      @(posedge clk);
      #1;
      fetch_valid = '0;
   endtask

   task automatic drain();
      while (exq.size() != 0) @(posedge clk);
   endtask

   // Monitor: one expected group per falling edge while the queue holds items.
   always @(negedge clk) begin
      if (exq.size() != 0) begin
         exp_t e;
         logic ok;
         e  = exq.pop_front();
         ok = (issue_valid == e.mask);
         for (int s = 0; s < 4; s++) begin
            if (e.mask[s] && ((issue_unit[3*s +: 3] != e.unit[3*s +: 3]) ||
                              (issue_dst[5*s +: 5] != e.dst[5*s +: 5]))) begin
               ok = 1'b0;
            end
         end
         check(ok, $sformatf("%s group: valid=%b unit=%h dst=%h, expected valid=%b unit=%h dst=%h (masked slots)",
                             e.tag, issue_valid, issue_unit, issue_dst, e.mask, e.unit, e.dst));
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired before the test sequence ended");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(issue_valid == 4'b0000, $sformatf("R1 reset issue_valid=%b expected 0000", issue_valid));
      check(fetch_ready == 4'b1111, $sformatf("R1 reset fetch_ready=%b expected 1111", fetch_ready));

      // R3: four independent, full group
      load(op_int(1, 20, 21), op_fp(2, 22, 23), op_int(3, 24, 25), op_fp(4, 26, 27));
      push(4'b1111, u4(0, 2, 1, 3), d4(1, 2, 3, 4), "R3");
      push(4'b0000, '0, '0, "R3");
      drain();

      // R4: third integer exceeds the integer budget; R8 survivors shift up
      load(op_int(1, 20, 21), op_int(2, 22, 23), op_int(3, 24, 25), op_fp(4, 26, 27));
      push(4'b0011, u4(0, 1, 0, 0), d4(1, 2, 0, 0), "R4");
      push(4'b0011, u4(0, 2, 0, 0), d4(3, 4, 0, 0), "R4 R8");
      push(4'b0000, '0, '0, "R4");
      drain();

      // R5: a load may not take the last slot
      load(op_int(1, 20, 21), op_int(2, 22, 23), op_fp(3, 24, 25), op_ld(4, 26));
      push(4'b0111, u4(0, 1, 2, 0), d4(1, 2, 3, 0), "R5");
      push(4'b0001, u4(4, 0, 0, 0), d4(4, 0, 0, 0), "R5");
      push(4'b0000, '0, '0, "R5");
      drain();

      // R6: integer consumer of an integer producer stops the group
      load(op_int(5, 20, 21), op_int(6, 5, 22), op_fp(7, 23, 24), op_br());
      push(4'b0001, u4(0, 0, 0, 0), d4(5, 0, 0, 0), "R6");
      push(4'b0111, u4(0, 2, 5, 0), d4(6, 7, 9, 0), "R6");
      push(4'b0000, '0, '0, "R6");
      drain();

      // R6: store data from an integer producer issues in the same group
      load(op_int(5, 20, 21), op_st(12, 5), op_fp(7, 23, 24), op_fp(8, 25, 26));
      push(4'b1111, u4(0, 4, 2, 3), d4(5, 13, 7, 8), "R6");
      push(4'b0000, '0, '0, "R6");
      drain();

      // R6: store address from the producer is not exempt
      load(op_int(5, 20, 21), op_st(5, 14), op_int(6, 22, 23), op_fp(7, 24, 25));
      push(4'b0001, u4(0, 0, 0, 0), d4(5, 0, 0, 0), "R6");
      push(4'b0111, u4(4, 0, 2, 0), d4(13, 6, 7, 0), "R6");
      push(4'b0000, '0, '0, "R6");
      drain();

      // R6: store data from an FP producer is not exempt
      load(op_fp(5, 20, 21), op_st(12, 5), op_int(6, 22, 23), op_int(7, 24, 25));
      push(4'b0001, u4(2, 0, 0, 0), d4(5, 0, 0, 0), "R6");
      push(4'b0111, u4(4, 0, 1, 0), d4(13, 6, 7, 0), "R6");
      push(4'b0000, '0, '0, "R6");
      drain();

      // R7: a branch closes the group
      load(op_int(1, 20, 21), op_br(), op_int(3, 22, 23), op_fp(4, 24, 25));
      push(4'b0011, u4(0, 5, 0, 0), d4(1, 9, 0, 0), "R7");
      push(4'b0011, u4(0, 2, 0, 0), d4(3, 4, 0, 0), "R7 R8");
      push(4'b0000, '0, '0, "R7");
      drain();

      // R2 R8: refill on the cycle of a partial issue; lanes past the free count are not taken
      load(op_int(1, 20, 21), op_int(2, 22, 23), op_int(3, 24, 25), op_int(4, 26, 27));
      push(4'b0011, u4(0, 1, 0, 0), d4(1, 2, 0, 0), "R2 R8");
      push(4'b1111, u4(0, 1, 2, 3), d4(3, 4, 10, 11), "R2 R8");
      push(4'b0000, '0, '0, "R2");
      @(negedge clk);
      #1;
      check(fetch_ready == 4'b0011, $sformatf("R2 ready with two free: %b expected 0011", fetch_ready));
      set_lanes(op_fp(10, 22, 23), op_fp(11, 24, 25), op_int(20, 26, 27), op_int(21, 28, 28), 4'b1111);
      @(posedge clk);
      #1;
      fetch_valid = '0;
      drain();
      #1;
      check(fetch_ready == 4'b1111, $sformatf("R2 ready when empty: %b expected 1111", fetch_ready));

      // R9: flush discards the two remaining entries
      load(op_int(1, 20, 21), op_int(2, 22, 23), op_int(3, 24, 25), op_int(4, 26, 27));
      push(4'b0011, u4(0, 1, 0, 0), d4(1, 2, 0, 0), "R9");
      drain();
      @(negedge clk);
      #1;
      check(issue_valid == 4'b0011 && issue_dst[9:0] == d4(3, 4, 0, 0)[9:0],
            $sformatf("R8 survivors valid=%b dst=%h expected 0011 with dst 3,4", issue_valid, issue_dst[9:0]));
      flush = 1'b1;
      #1;
      check(issue_valid == 4'b0000 && fetch_ready == 4'b0000,
            $sformatf("R9 during flush valid=%b ready=%b expected 0000 0000", issue_valid, fetch_ready));
      @(posedge clk);
      #1;
      flush = 1'b0;
      @(negedge clk);
      check(issue_valid == 4'b0000 && fetch_ready == 4'b1111,
            $sformatf("R9 after flush valid=%b ready=%b expected 0000 1111", issue_valid, fetch_ready));

      repeat (2) @(posedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule